// File: doc/BRIEF.md
# Two-Level Granule Protection Table Walker

The walker turns a physical address into the 4-bit protection index that governs it. It reads a two-level table held in memory. Each level-0 entry either names the index for a whole region directly or points to a level-1 table. Each level-1 entry either covers a contiguous span with one index or packs sixteen per-granule indices. Static configuration pins select the protected-space size, the granule size, the level-0 region size and the level-0 table base. The walker rejects addresses beyond the protected space, invalid configuration codes and level-0 entries of unknown type.

Lookups enter through a valid/ready request port. `req_ready` is high only while the walker is idle, so a request is held off for the whole of a walk. Results leave as a single-cycle `rsp_valid` pulse with no back-pressure, so the consumer must take the result in that cycle. Table reads use a one-beat request port. `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is seen. `mem_rsp_valid` is accepted in any cycle while a read is outstanding. The configuration must not change while a walk is in progress.

Top module: `gpt_walker`

## Requirements
- R1: `req_ready` is 1 only while no walk is in progress. A request is taken on a cycle with `req_valid` and `req_ready` both high, and `req_ready` is 0 from the next cycle until the result has been delivered.
- R2: Each accepted request produces exactly one result: `rsp_valid` high for a single cycle, carrying `rsp_gpi` and `rsp_fault`. A faulting result carries index 0, and `req_ready` returns in the cycle after the pulse.
- R3: Protected-space code c gives width T: 0→32, 1→36, 2→40, 3→42, 4→44, 5→48, 6→52. Granule code g gives exponent P: 0→12, 2→14, 1→16. A space code of 7 or a granule code of 3 gives a fault with no table read.
- R4: An address with any bit at position T or above set gives a fault with no table read.
- R5: The first read goes to base + (PA >> S)·8, where S = region-size field + 30. When S ≥ T this is always entry 0.
- R6: A level-0 entry with bits [3:0] = 1 ends the walk after one read, with the index taken from bits [7:4].
- R7: A level-0 entry with bits [3:0] = 3 causes a second read at {entry[51:12], 12'b0} + PA[S-1:P+4]·8.
- R8: A level-0 entry with any other type value ends the walk with a fault after one read.
- R9: A level-1 entry with bits [3:0] = 1 and bits [9:8] ≠ 0 is contiguous, and its index is bits [7:4].
- R10: Any other level-1 entry is a granules entry. Its index is the nibble at bits [4n+3:4n] with n = PA[P+3:P]. This covers a low nibble of 1 with bits [9:8] = 0.
- R11: A table read holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready`, and each walk issues at most two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pps | input | 3 | Protected-space size code |
| cfg_pgs | input | 2 | Granule size code |
| cfg_l0sz | input | 4 | Level-0 region size field (S − 30) |
| cfg_l0_base | input | 52 | Level-0 table byte address, 8-byte aligned |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_pa | input | 52 | Physical address to look up |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_gpi | output | 4 | Protection index result |
| rsp_fault | output | 1 | Result is a fault |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Table read accepted |
| mem_req_addr | output | 52 | Table read byte address |
| mem_rsp_valid | input | 1 | Table read data present |
| mem_rsp_data | input | 64 | Table read data |

## Verification
Random addresses are drawn under random valid configurations and compared with a table model whose entries are derived by hashing their addresses. A wrong level-0 or level-1 read address therefore shows up as a wrong index, and the recorded read addresses are also compared directly. Directed cases cover the invalid space and granule codes, addresses one bit beyond T, and an S ≥ T setup that must always read entry 0. These separate the fault paths that issue no read from the path that faults after one read. A memory port with random ready and random latency confirms that request holding and the single-pulse result do not depend on memory timing. The read count per walk tells block, table and fault terminations apart.

// File: rtl/gpt_walk_pkg.sv
package gpt_walk_pkg;
  localparam int EXP_W = 6;
  localparam logic [3:0] L0_TYPE_BLOCK = 4'h1;
  localparam logic [3:0] L0_TYPE_TABLE = 4'h3;
  localparam logic [3:0] L1_CONT_TAG   = 4'h1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L0_REQ, ST_L0_WAIT, ST_L1_REQ, ST_L1_WAIT, ST_DONE
  } walk_state_e;

  function automatic logic [EXP_W-1:0] space_width(input logic [2:0] code);
    case (code)
      3'd0: return 6'd32;
      3'd1: return 6'd36;
      3'd2: return 6'd40;
      3'd3: return 6'd42;
      3'd4: return 6'd44;
      3'd5: return 6'd48;
      default: return 6'd52;
    endcase
  endfunction

  function automatic logic [4:0] granule_exp(input logic [1:0] code);
    case (code)
      2'b10: return 5'd14;
      2'b01: return 5'd16;
      default: return 5'd12;
    endcase
  endfunction
endpackage

// File: rtl/gpt_cfg_decode.sv
module gpt_cfg_decode
  import gpt_walk_pkg::*;
(
  input  logic [2:0]       cfg_pps,
  input  logic [1:0]       cfg_pgs,
  input  logic [3:0]       cfg_l0sz,
  output logic [EXP_W-1:0] t_exp,
  output logic [EXP_W-1:0] s_exp,
  output logic [4:0]       p_exp,
  output logic             cfg_ok
);
  // R3: non-monotonic granule code, space codes above 6 rejected
  assign t_exp  = space_width(cfg_pps);
  assign p_exp  = granule_exp(cfg_pgs);
  assign s_exp  = EXP_W'(cfg_l0sz) + EXP_W'(30);
  assign cfg_ok = (cfg_pps != 3'd7) && (cfg_pgs != 2'b11);
endmodule

// File: rtl/gpt_desc_decode.sv
module gpt_desc_decode
  import gpt_walk_pkg::*;
#(
  parameter int PA_W = 52
) (
  input  logic [63:0]      desc,
  input  logic [PA_W-1:0]  pa,
  input  logic [EXP_W-1:0] s_exp,
  input  logic [4:0]       p_exp,
  output logic             l0_is_block,
  output logic             l0_is_table,
  output logic [3:0]       l0_gpi,
  output logic [PA_W-1:0]  l1_addr,
  output logic [3:0]       l1_gpi
);
  localparam int NIBBLES = 16;

  logic [3:0]  nib [NIBBLES];
  logic [3:0]  nib_sel;
  logic [63:0] pa_in_region;
  logic [63:0] l1_index;
  logic        is_contig;

  // level-0 type field
  assign l0_is_block = (desc[3:0] == L0_TYPE_BLOCK);
  assign l0_is_table = (desc[3:0] == L0_TYPE_TABLE);
  assign l0_gpi      = desc[7:4];

  // R7: level-1 entry address from table pointer and PA[S-1:P+4]
  assign pa_in_region = 64'(pa) & ((64'd1 << s_exp) - 64'd1);
  assign l1_index     = pa_in_region >> (p_exp + 5'd4);
  assign l1_addr      = {desc[PA_W-1:12], 12'b0} + PA_W'(l1_index << 3);

  // R10: granules entry as sixteen nibbles
  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    assign nib[g] = desc[4*g+3:4*g];
  end
  assign nib_sel = 4'(64'(pa) >> p_exp);

  // R9: contiguous entry needs tag 1 and a nonzero span
  assign is_contig = (desc[3:0] == L1_CONT_TAG) && (desc[9:8] != 2'b00);
  assign l1_gpi    = is_contig ? desc[7:4] : nib[nib_sel];
endmodule

// File: rtl/gpt_walker.sv
module gpt_walker
  import gpt_walk_pkg::*;
#(
  parameter int PA_W = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cfg_pps,
  input  logic [1:0]      cfg_pgs,
  input  logic [3:0]      cfg_l0sz,
  input  logic [PA_W-1:0] cfg_l0_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PA_W-1:0] req_pa,
  output logic            rsp_valid,
  output logic [3:0]      rsp_gpi,
  output logic            rsp_fault,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data
);
  walk_state_e      state;
  logic [PA_W-1:0]  pa_q;
  logic [PA_W-1:0]  addr_q;
  logic [3:0]       gpi_q;
  logic             fault_q;

  logic [EXP_W-1:0] t_exp, s_exp;
  logic [4:0]       p_exp;
  logic             cfg_ok;
  logic             out_of_range;
  logic [PA_W-1:0]  l0_addr;
  logic             l0_is_block, l0_is_table;
  logic [3:0]       l0_gpi, l1_gpi;
  logic [PA_W-1:0]  l1_addr;
  logic             accept;

  gpt_cfg_decode u_cfg (
    .cfg_pps (cfg_pps),
    .cfg_pgs (cfg_pgs),
    .cfg_l0sz(cfg_l0sz),
    .t_exp   (t_exp),
    .s_exp   (s_exp),
    .p_exp   (p_exp),
    .cfg_ok  (cfg_ok)
  );

  gpt_desc_decode #(.PA_W(PA_W)) u_desc (
    .desc       (mem_rsp_data),
    .pa         (pa_q),
    .s_exp      (s_exp),
    .p_exp      (p_exp),
    .l0_is_block(l0_is_block),
    .l0_is_table(l0_is_table),
    .l0_gpi     (l0_gpi),
    .l1_addr    (l1_addr),
    .l1_gpi     (l1_gpi)
  );

  // R4: any address bit at or above T
  assign out_of_range = ((64'(req_pa) >> t_exp) != 64'd0);
  // R5: level-0 entry address
  assign l0_addr      = cfg_l0_base + PA_W'((64'(req_pa) >> s_exp) << 3);

  assign accept        = req_valid && req_ready;
  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_DONE);
  assign rsp_gpi       = gpi_q;
  assign rsp_fault     = fault_q;
  assign mem_req_valid = (state == ST_L0_REQ) || (state == ST_L1_REQ);
  assign mem_req_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pa_q    <= '0;
      addr_q  <= '0;
      gpi_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          pa_q <= req_pa;
          if (!cfg_ok || out_of_range) begin
            gpi_q   <= '0;
            fault_q <= 1'b1;
            state   <= ST_DONE;
          end else begin
            addr_q <= l0_addr;
            state  <= ST_L0_REQ;
          end
        end
        ST_L0_REQ: if (mem_req_ready) state <= ST_L0_WAIT;
        ST_L0_WAIT: if (mem_rsp_valid) begin
          if (l0_is_block) begin
            gpi_q   <= l0_gpi;
            fault_q <= 1'b0;
            state   <= ST_DONE;
          end else if (l0_is_table) begin
            addr_q <= l1_addr;
            state  <= ST_L1_REQ;
          end else begin
            gpi_q   <= '0;
            fault_q <= 1'b1;
            state   <= ST_DONE;
          end
        end
        ST_L1_REQ: if (mem_req_ready) state <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          gpi_q   <= l1_gpi;
          fault_q <= 1'b0;
          state   <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R2
  AST_RANGE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && out_of_range) |=> (rsp_valid && rsp_fault && !mem_req_valid)); // R4
  AST_BAD_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_L0_WAIT && mem_rsp_valid && !l0_is_block && !l0_is_table)
      |=> (rsp_valid && rsp_fault)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11
endmodule

// File: tb/tb_gpt_walker.sv
`timescale 1ns/1ps
module tb_gpt_walker;
  localparam int PA_W = 52;
  localparam logic [51:0] L0_BASE = 52'h0_1000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_pps = '0;
  logic [1:0] cfg_pgs = '0;
  logic [3:0] cfg_l0sz = '0;
  logic [51:0] cfg_l0_base = L0_BASE;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [51:0] req_pa = '0;
  logic rsp_valid;
  logic [3:0] rsp_gpi;
  logic rsp_fault;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [51:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [51:0] rd_log [4];
  int rd_cnt = 0;

  always #2 clk = ~clk;   // 250 MHz

  gpt_walker #(.PA_W(PA_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_pps(cfg_pps), .cfg_pgs(cfg_pgs),
    .cfg_l0sz(cfg_l0sz), .cfg_l0_base(cfg_l0_base), .req_valid(req_valid),
    .req_ready(req_ready), .req_pa(req_pa), .rsp_valid(rsp_valid),
    .rsp_gpi(rsp_gpi), .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [63:0] mix(input logic [63:0] v);
    logic [63:0] x = v;
    x = x ^ (x >> 31);
    x = x * 64'hBF58476D1CE4E5B9;
    x = x ^ (x >> 29);
    x = x * 64'h94D049BB133111EB;
    x = x ^ (x >> 32);
    return x;
  endfunction

  // table contents as a function of the read address
  function automatic logic [63:0] mem_word(input logic [51:0] a);
    logic [63:0] h, w, idx;
    logic [39:0] fld;
    logic [1:0] span;
    if (a[46]) begin
      h = mix(64'(a) ^ 64'h55);
      case (h[61:60])
        2'd0: begin
          span = 2'(h[59:58] % 2'd3) + 2'd1;
          w = {h[63:10], span, h[7:4], 4'h1};
        end
        2'd1: w = {h[63:10], 2'b00, h[7:4], 4'h1};
        default: begin
          w = h;
          if (w[3:0] == 4'h1 && w[9:8] != 2'b00) w[3:0] = 4'h2;
        end
      endcase
    end else begin
      idx = 64'(a - L0_BASE) >> 3;
      h = mix(idx);
      fld = 40'h4_0000_0000 | (40'(idx[15:0]) << 12);
      case (h[62:60])
        3'd0, 3'd1: w = {h[63:8], h[7:4], 4'h1};
        3'd2: w = {h[63:4], (h[3:0] == 4'h1 || h[3:0] == 4'h3) ? 4'h0 : h[3:0]};
        default: w = {h[63:52], fld, h[11:4], 4'h3};
      endcase
    end
    return w;
  endfunction

  // reference walk; path: 0 cfg, 1 range, 2 block, 3 bad type, 4 contig, 5 granules
  task automatic model(input logic [51:0] pa, input logic [2:0] pps, input logic [1:0] pgs,
                       input logic [3:0] l0sz, output logic [3:0] gpi, output logic fault,
                       output int n, output logic [51:0] a0, output logic [51:0] a1,
                       output int path);
    int t, s, p;
    logic [63:0] d, e, idx;
    int nb;
    gpi = 0; fault = 1; n = 0; a0 = 0; a1 = 0;
    if (pps == 3'd7 || pgs == 2'b11) begin path = 0; return; end
    case (pps)
      3'd0: t = 32; 3'd1: t = 36; 3'd2: t = 40; 3'd3: t = 42;
      3'd4: t = 44; 3'd5: t = 48; default: t = 52;
    endcase
    p = (pgs == 2'b00) ? 12 : (pgs == 2'b10) ? 14 : 16;
    s = int'(l0sz) + 30;
    if ((64'(pa) >> t) != 0) begin path = 1; return; end
    a0 = L0_BASE + 52'((64'(pa) >> s) * 8);
    n = 1;
    d = mem_word(a0);
    if (d[3:0] == 4'h1) begin gpi = d[7:4]; fault = 0; path = 2; return; end
    if (d[3:0] != 4'h3) begin path = 3; return; end
    idx = (64'(pa) & ((64'd1 << s) - 1)) >> (p + 4);
    a1 = {d[51:12], 12'b0} + 52'(idx * 8);
    n = 2;
    e = mem_word(a1);
    fault = 0;
    if (e[3:0] == 4'h1 && e[9:8] != 2'b00) begin gpi = e[7:4]; path = 4; end
    else begin nb = int'((64'(pa) >> p) & 64'hF); gpi = 4'(e >> (4 * nb)); path = 5; end
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder: random ready, random latency
  initial begin
    logic busy = 1'b0;
    int lat = 0;
    logic [51:0] cap = '0;
    bit r;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) begin mem_rsp_valid = 1'b0; busy = 1'b0; end
      if (busy) begin
        mem_req_ready = 1'b0;
        if (lat == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = mem_word(cap); end
        else lat--;
      end else begin
        r = ($urandom % 4) != 0;
        mem_req_ready = r;
        if (r && mem_req_valid && rst_n) begin
          cap = mem_req_addr;
          if (rd_cnt < 4) rd_log[rd_cnt] = mem_req_addr;
          rd_cnt++;
          busy = 1'b1;
          lat = $urandom % 3;
        end
      end
    end
  end

  task automatic walk(input logic [51:0] pa, input logic [2:0] pps, input logic [1:0] pgs,
                      input logic [3:0] l0sz);
    logic [3:0] egpi; logic ef; int en, path, wait_c; logic [51:0] ea0, ea1;
    string tag;
    bit busy_ok;
    model(pa, pps, pgs, l0sz, egpi, ef, en, ea0, ea1, path);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_pps = pps; cfg_pgs = pgs; cfg_l0sz = l0sz;
    rd_cnt = 0;
    req_pa = pa; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_c = 0;
    busy_ok = 1;
    while (!rsp_valid && wait_c < 100) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk); wait_c++;
    end
    check(busy_ok, "R1 ready low during walk", 64'(busy_ok), 1);
    if (wait_c >= 100) begin check(0, "R2 result timeout", 0, 1); return; end
    case (path)
      0: tag = "R3"; 1: tag = "R4"; 2: tag = "R6";
      3: tag = "R8"; 4: tag = "R9"; default: tag = "R10";
    endcase
    check(rsp_fault == ef, {tag, " fault"}, 64'(rsp_fault), 64'(ef));
    check(rsp_gpi == egpi, {tag, " gpi"}, 64'(rsp_gpi), 64'(egpi));
    check(rd_cnt == en, {tag, " R11 read count"}, 64'(rd_cnt), 64'(en));
    if (en >= 1 && rd_cnt >= 1) check(rd_log[0] == ea0, "R5 level-0 address", 64'(rd_log[0]), 64'(ea0));
    if (en == 2 && rd_cnt >= 2) check(rd_log[1] == ea1, "R7 level-1 address", 64'(rd_log[1]), 64'(ea1));
    @(negedge clk);
    check(!rsp_valid && req_ready, "R2 single pulse", 64'({rsp_valid, req_ready}), 64'b01);
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    check(0, "watchdog", 64'(cycles), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] pps; logic [1:0] pgs; logic [3:0] l0sz; logic [51:0] pa; int t;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
          64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);
    // directed corners
    walk(52'h1234, 3'd7, 2'b00, 4'd0);                 // R3 bad space code
    walk(52'h1234, 3'd2, 2'b11, 4'd0);                 // R3 bad granule code
    walk(52'h1_0000_0000, 3'd0, 2'b00, 4'd0);          // R4 bit T set
    walk(52'h0_FFFF_FFFF, 3'd0, 2'b00, 4'd0);          // R4 just inside
    walk(52'h0_8765_4321, 3'd0, 2'b10, 4'd5);          // R5 S >= T
    walk(52'h0_0123_4567, 3'd0, 2'b01, 4'd9);          // R5 S >= T
    for (int i = 0; i < 400; i++) begin
      pps = 3'($urandom % 7);
      pgs = 2'($urandom % 3);
      l0sz = 4'($urandom % 10);
      case (pps)
        3'd0: t = 32; 3'd1: t = 36; 3'd2: t = 40; 3'd3: t = 42;
        3'd4: t = 44; 3'd5: t = 48; default: t = 52;
      endcase
      pa = {20'($urandom), $urandom} & 52'((64'd1 << t) - 1);
      if ($urandom % 16 == 0 && t < 52) pa[t + ($urandom % (52 - t))] = 1'b1;  // R4
      walk(pa, pps, pgs, l0sz);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule